// File: doc/BRIEF.md
# Six-Level Priority Interrupt Controller

This block arbitrates six interrupt request levels for a 16-bit word-addressed processor. Level 0 is the most urgent and level 5 the least. Each accepted level is marked as in service and stays marked until software dismisses it. While any level is in service, requests at that level and at every less urgent level are held off. A more urgent request still gets through and nests on top of the level already in service.

The sequencer raises an instruction-boundary strobe whenever it could take an interrupt. On such a cycle the block chooses the most urgent eligible request. One cycle later it pulses an accept output and presents two values: the winning level and the word address of that level's handler pointer, which is eight plus the level number. The sequencer then performs the indirect branch-and-store through that address.

An I/O command loads per-level mask bits that gate requests before arbitration. A dismiss pulse from software clears the most urgent in-service bit. On a slow processor model, a fast-cycle select output is raised while level 0 or level 1 is in service.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the in-service vector is 0, all mask bits are 0 (every level enabled), the accept pulse is low and the fast-cycle select is low.
- R2: When the boundary strobe is high, the lowest-numbered request that is unmasked and eligible wins arbitration.
- R3: The cycle after the winning boundary cycle, `take_o` is high for exactly one cycle, `level_o` holds the level number, and `vec_addr_o` equals 0x0008 plus that level (0x0008 to 0x000D).
- R4: No request is accepted in a cycle where `boundary_i` is low, and in that case the in-service vector does not change.
- R5: While levels are in service, a request is eligible only if its number is smaller than the smallest in-service level. An accepted level is added to the existing in-service bits, and the bits already set are kept.
- R6: An in-service bit stays set until a dismiss pulse clears it. The pulse clears only the lowest-numbered set bit.
- R7: When dismiss and boundary occur in the same cycle, arbitration uses the in-service vector with the dismissed bit already cleared.
- R8: A cycle with `mask_load_i` high copies `mask_data_i` into the mask. Mask bit n set to 1 blocks level n. Loading the mask does not change the in-service vector.
- R9: `fast_cycle_o` is high exactly when `slow_model_i` is high and bit 0 or bit 1 of the in-service vector is set.
- R10: A dismiss pulse while nothing is in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Request lines, bit n is level n |
| mask_load_i | input | 1 | Load strobe for the mask |
| mask_data_i | input | 6 | New mask value, 1 blocks that level |
| boundary_i | input | 1 | Instruction-boundary strobe from the sequencer |
| dismiss_i | input | 1 | Clears the most urgent in-service level |
| slow_model_i | input | 1 | Set on the slow processor model |
| take_o | output | 1 | One-cycle accept pulse |
| level_o | output | 3 | Level of the last accepted request |
| vec_addr_o | output | 16 | Word address of the handler pointer |
| in_service_o | output | 6 | In-service bits |
| fast_cycle_o | output | 1 | Fast memory-cycle select |

## Verification
The bench tries every combination of request pattern and mask, and checks the winner each time. A priority encoder that favoured high level numbers, or that ignored the mask, would report the wrong level or vector address. It also tries every pair of an in-service level and a new request level. An off-by-one in the eligibility compare would then either let an equal-level request nest or block a more urgent one. Two further cases are covered. In the first, dismiss and boundary arrive in the same cycle; a design that arbitrates against the stale in-service vector would refuse the waiting request. In the second, dismiss arrives while nothing is in service, or a mask load happens while a level is in service; a design that handled either carelessly would corrupt the in-service bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IRQ_LEVELS   = 6;
    localparam int IRQ_ADDR_W   = 16;
    localparam int IRQ_VEC_BASE = 8;
    localparam int IRQ_FAST_LVL = 2;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 6,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // lowest index wins
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] data_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (load_i) mask_d = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
    parameter int NUM_LVL   = irq_pkg::IRQ_LEVELS,
    parameter int ADDR_W    = irq_pkg::IRQ_ADDR_W,
    parameter int VEC_BASE  = irq_pkg::IRQ_VEC_BASE,
    parameter int FAST_LVLS = irq_pkg::IRQ_FAST_LVL,
    localparam int LW       = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] req_i,
    input  logic               mask_load_i,
    input  logic [NUM_LVL-1:0] mask_data_i,
    input  logic               boundary_i,
    input  logic               dismiss_i,
    input  logic               slow_model_i,
    output logic               take_o,
    output logic [LW-1:0]      level_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic [NUM_LVL-1:0] in_service_o,
    output logic               fast_cycle_o
);
    typedef struct packed {
        logic [NUM_LVL-1:0] isr;
        logic               take;
        logic [LW-1:0]      lvl;
        logic [ADDR_W-1:0]  vec;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LVL-1:0] mask_q;
    logic [NUM_LVL-1:0] isr_eff, eligible, cand;
    logic               top_any, eff_any, pick_any;
    logic [LW-1:0]      top_idx, eff_idx, pick_idx;

    irq_mask_reg #(.N(NUM_LVL)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (mask_load_i),
        .data_i (mask_data_i),
        .mask_o (mask_q)
    );

    // most urgent level now in service (dismiss target)
    irq_prio_enc #(.N(NUM_LVL), .IW(LW)) u_top (
        .vec_i (st_q.isr), .any_o (top_any), .idx_o (top_idx)
    );

    always_comb begin
        isr_eff = st_q.isr;
        if (dismiss_i && top_any) isr_eff[top_idx] = 1'b0;
    end

    // most urgent level still in service after this cycle's dismiss
    irq_prio_enc #(.N(NUM_LVL), .IW(LW)) u_eff (
        .vec_i (isr_eff), .any_o (eff_any), .idx_o (eff_idx)
    );

    always_comb begin
        for (int i = 0; i < NUM_LVL; i++) begin
            eligible[i] = !eff_any || (i < int'(eff_idx));
        end
        cand = req_i & ~mask_q & eligible;
    end

    irq_prio_enc #(.N(NUM_LVL), .IW(LW)) u_pick (
        .vec_i (cand), .any_o (pick_any), .idx_o (pick_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.isr  = isr_eff;
        st_d.take = 1'b0;
        if (boundary_i && pick_any) begin
            st_d.take          = 1'b1;
            st_d.isr[pick_idx] = 1'b1;
            st_d.lvl           = pick_idx;
            st_d.vec           = ADDR_W'(VEC_BASE) + ADDR_W'(pick_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o       = st_q.take;
    assign level_o      = st_q.lvl;
    assign vec_addr_o   = st_q.vec;
    assign in_service_o = st_q.isr;
    assign fast_cycle_o = slow_model_i && (|st_q.isr[FAST_LVLS-1:0]);

    // R4
    take_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i));

    // R3
    taken_level_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> in_service_o[level_o]);

    // R3
    vec_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vec_addr_o >= ADDR_W'(VEC_BASE) &&
                    vec_addr_o <  ADDR_W'(VEC_BASE + NUM_LVL)));

    // R6
    isr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dismiss_i) |-> ((in_service_o & $past(in_service_o)) == $past(in_service_o)));

    // R9
    fast_only_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_cycle_o |-> slow_model_i);

    // R10
    idle_dismiss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dismiss_i) && $past(in_service_o) == '0 && !take_o) |-> in_service_o == '0);
endmodule

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] req_i = '0;
    logic       mask_load_i = 1'b0;
    logic [5:0] mask_data_i = '0;
    logic       boundary_i = 1'b0;
    logic       dismiss_i = 1'b0;
    logic       slow_model_i = 1'b0;
    logic       take_o;
    logic [2:0] level_o;
    logic [15:0] vec_addr_o;
    logic [5:0] in_service_o;
    logic       fast_cycle_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_level_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_load_i(mask_load_i),
        .mask_data_i(mask_data_i), .boundary_i(boundary_i), .dismiss_i(dismiss_i),
        .slow_model_i(slow_model_i), .take_o(take_o), .level_o(level_o),
        .vec_addr_o(vec_addr_o), .in_service_o(in_service_o), .fast_cycle_o(fast_cycle_o)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        req_i = '0; boundary_i = 0; dismiss_i = 0; mask_load_i = 0;
    endtask

    task automatic clear_all();
        idle();
        dismiss_i = 1;
        for (int k = 0; k < 6; k++) cyc();
        dismiss_i = 0;
    endtask

    task automatic load_mask(input logic [5:0] m);
        idle();
        mask_load_i = 1; mask_data_i = m;
        cyc();
        mask_load_i = 0;
    endtask

    task automatic take_lvl(input int l);
        idle();
        req_i = 6'(1 << l); boundary_i = 1;
        cyc();
        idle();
    endtask

    function automatic int lowest(input logic [5:0] v);
        for (int i = 0; i < 6; i++) if (v[i]) return i;
        return -1;
    endfunction

    initial begin
        #2000000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(in_service_o == 0, "R1 isr", in_service_o, 0);
        chk(take_o == 0, "R1 take", take_o, 0);
        chk(fast_cycle_o == 0, "R1 fast", fast_cycle_o, 0);
        rst_n = 1;
        cyc();
        // R1 mask all-enabled: level 5 accepted right away
        take_lvl(5);
        chk(take_o == 1 && level_o == 5, "R1 mask reset", level_o, 5);
        clear_all();

        // R2 R3 R8 sweep over every mask and request pattern
        for (int m = 0; m < 64; m++) begin
            load_mask(6'(m));
            for (int p = 0; p < 64; p++) begin
                logic [5:0] g;
                int w;
                g = 6'(p) & ~6'(m);
                w = lowest(g);
                req_i = 6'(p); boundary_i = 1;
                cyc();
                idle();
                chk(take_o == (w >= 0), "R2 take", take_o, int'(w >= 0));
                if (w >= 0) begin
                    chk(level_o == 3'(w), "R2 level", level_o, w);
                    chk(vec_addr_o == 16'(8 + w), "R3 vec", vec_addr_o, 8 + w);
                    chk(in_service_o == 6'(1 << w), "R5 isr", in_service_o, 1 << w);
                end
                dismiss_i = 1;
                cyc();
                dismiss_i = 0;
                chk(take_o == 0, "R3 pulse", take_o, 0);
                chk(in_service_o == 0, "R6 dismiss", in_service_o, 0);
            end
        end
        load_mask(6'h00);

        // R5 R6 R9 nesting over every pair
        slow_model_i = 1;
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 6; b++) begin
                int e;
                clear_all();
                take_lvl(a);
                take_lvl(b);
                e = (1 << a) | ((b < a) ? (1 << b) : 0);
                chk(take_o == (b < a), "R5 nest take", take_o, int'(b < a));
                chk(in_service_o == 6'(e), "R5 nest isr", in_service_o, e);
                chk(fast_cycle_o == ((e & 3) != 0), "R9 fast", fast_cycle_o, int'((e & 3) != 0));
                dismiss_i = 1;
                cyc();
                dismiss_i = 0;
                e = (b < a) ? (1 << a) : 0;
                chk(in_service_o == 6'(e), "R6 dismiss order", in_service_o, e);
            end
        end
        // R9 fast select off when not slow model
        clear_all();
        take_lvl(0);
        slow_model_i = 0;
        #1;
        chk(fast_cycle_o == 0, "R9 not slow", fast_cycle_o, 0);
        slow_model_i = 1;
        #1;
        chk(fast_cycle_o == 1, "R9 slow", fast_cycle_o, 1);

        // R4 no boundary, no acceptance
        clear_all();
        req_i = 6'h3f;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk(take_o == 0 && in_service_o == 0, "R4 no boundary", in_service_o, 0);
        end

        // R6 level held until dismissed; lower level blocked long
        clear_all();
        take_lvl(4);
        req_i = 6'h20; boundary_i = 1;
        for (int k = 0; k < 20; k++) cyc();
        idle();
        chk(in_service_o == 6'h10 && take_o == 0, "R6 held", in_service_o, 6'h10);

        // R7 dismiss and boundary together
        clear_all();
        take_lvl(1);
        req_i = 6'h08; boundary_i = 1; dismiss_i = 1;
        cyc();
        idle();
        chk(take_o == 1 && level_o == 3, "R7 same cycle level", level_o, 3);
        chk(in_service_o == 6'h08, "R7 same cycle isr", in_service_o, 8);

        // R10 dismiss while idle
        clear_all();
        dismiss_i = 1;
        cyc();
        dismiss_i = 0;
        chk(in_service_o == 0 && take_o == 0, "R10 idle dismiss", in_service_o, 0);
        take_lvl(2);
        chk(in_service_o == 6'h04, "R10 after", in_service_o, 4);

        // R8 mask load keeps in-service, blocks, then unblocks
        load_mask(6'h3f);
        chk(in_service_o == 6'h04, "R8 isr kept", in_service_o, 4);
        take_lvl(0);
        chk(take_o == 0, "R8 masked", take_o, 0);
        load_mask(6'h3e);
        take_lvl(0);
        chk(take_o == 1 && in_service_o == 6'h05, "R8 unmasked", in_service_o, 5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule